// File: doc/BRIEF.md
# Fused Two-Product Montgomery Multiplier with Delayed Quotient

This block computes a Montgomery-reduced sum of two products, (A·B + C·D)·2^-(DIG_W·N_DIG) mod M, in one iterative pass. It works with one radix-2^DIG_W digit of B and one of D per iteration. Both products and the modulus correction go into a single carry-save accumulation, so the sum of the two products costs no separate addition. A typical use is one extension-field product step inside a larger arithmetic engine. With C and D held at zero it is a plain Montgomery multiplier.

The quotient digit is taken from the low digit of the residue. It is applied to the residue one iteration later, so the short carry-propagate add that produces it runs beside the next carry-save update instead of in front of it. The host supplies a reduced modulus constant mod_hat = (M'·M + 1) / 2^(2·DIG_W), where M' = -M^-1 mod 2^(2·DIG_W) and M is odd. The datapath never sees M itself. The iteration count is N_DIG + 2: one extra iteration accounts for the radix factor built into the recurrence, and one drains the last delayed quotient. A final carry-propagate add joins the carry-save residue with the pending quotient digit. No conditional subtraction is done.

Top module: `qp_mont_mac`

## Requirements
- R1: While rst_ni is low and after its release, done_o is 0 and result_o is 0.
- R2: done_o is high for exactly one cycle, on the (N_DIG+3)-th rising edge after the edge that samples start_i high.
- R3: result_o·2^(DIG_W·N_DIG) ≡ a_i·b_i + c_i·d_i (mod M), where the operands are all sampled at the start edge and mod_hat_i = (M'·M + 1)/2^(2·DIG_W) with M' = -M^-1 mod 2^(2·DIG_W), M odd.
- R4: If M < 2^(OP_W-2·DIG_W-1) and all operands are below 2^OP_W, the full result is below 2^OP_W, so it fits result_o without truncation.
- R5: With c_i = d_i = 0 the result is the Montgomery product of a_i and b_i alone, meeting R3.
- R6: A result can be fed back as any operand of a new operation, and the new result still meets R3.
- R7: A start_i pulse while an operation is in progress is ignored. The running result and the done timing stay the same, and result_o keeps its previous value until done_o rises.
- R8: All-zero operands give a result of exactly zero.
- R9: Operands of all ones (2^OP_W - 1) together with the largest allowed modulus still meet R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins an operation when idle |
| a_i | input | OP_W | Operand A |
| b_i | input | OP_W | Operand B, consumed one digit per iteration |
| c_i | input | OP_W | Operand C |
| d_i | input | OP_W | Operand D, consumed one digit per iteration |
| mod_hat_i | input | OP_W | Reduced modulus constant (M'·M+1)/2^(2·DIG_W) |
| done_o | output | 1 | One-cycle strobe, result_o is valid |
| result_o | output | OP_W | Reduced result, held until the next done_o |

## Verification
The bench checks results by congruence against a wide-integer model that computes mod_hat from M itself. A wrongly timed quotient, a lost carry from the low digit, or a missing flush iteration each leave the result off by a multiple of 2^DIG_W or by a stray modulus term, and that shows up at once as a residue mismatch. All-ones operands with the largest modulus push the accumulator and the output bound to their limits, so truncating the final add breaks the congruence. A zero input must give exactly zero, which catches a quotient that is not cleared between operations. Feeding a result back as an operand exercises operands near the output bound. A start pulse with different operands in mid-run would corrupt the answer or shift done_o if the block restarted or re-read its inputs.

// File: rtl/qp_mont_pkg.sv
package qp_mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } qp_state_e;
endpackage

// File: rtl/qp_digit_cpa.sv
// Low-digit carry-propagate add: quotient digit plus carry into the shifted part.
module qp_digit_cpa #(
  parameter int unsigned DIG_W = 16
) (
  input  logic [DIG_W-1:0] sum_i,
  input  logic [DIG_W-1:0] carry_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] q_o,
  output logic             cout_o
);
  logic [DIG_W:0] tot;

  always_comb begin
    tot    = {1'b0, sum_i} + {1'b0, carry_i} + {{DIG_W{1'b0}}, cin_i};
    q_o    = tot[DIG_W-1:0];
    cout_o = tot[DIG_W];
  end
endmodule

// File: rtl/qp_pp_rows.sv
// One digit times one operand, as DIG_W shifted AND rows.
module qp_pp_rows #(
  parameter int unsigned DIG_W = 16,
  parameter int unsigned OP_W  = 78,
  parameter int unsigned ACC_W = 128
) (
  input  logic [DIG_W-1:0]            dig_i,
  input  logic [OP_W-1:0]             op_i,
  output logic [DIG_W-1:0][ACC_W-1:0] rows_o
);
  logic [ACC_W-1:0] op_ext;
  assign op_ext = ACC_W'(op_i);

  for (genvar j = 0; j < DIG_W; j++) begin : g_row
    assign rows_o[j] = dig_i[j] ? (op_ext << j) : '0;
  end
endmodule

// File: rtl/qp_csa_reduce.sv
// Compress NROW rows to a sum/carry pair with a chain of 3:2 counters.
module qp_csa_reduce #(
  parameter int unsigned NROW  = 50,
  parameter int unsigned ACC_W = 128
) (
  input  logic [NROW-1:0][ACC_W-1:0] rows_i,
  output logic [ACC_W-1:0]           sum_o,
  output logic [ACC_W-1:0]           carry_o,
  output logic                       ovf_o
);
  logic [ACC_W-1:0] s, c, maj;

  always_comb begin
    s     = rows_i[0];
    c     = rows_i[1];
    maj   = '0;
    ovf_o = 1'b0;
    for (int k = 2; k < NROW; k++) begin
      maj   = (s & c) | (s & rows_i[k]) | (c & rows_i[k]);
      ovf_o = ovf_o | maj[ACC_W-1];
      s     = s ^ c ^ rows_i[k];
      c     = maj << 1;
    end
    sum_o   = s;
    carry_o = c;
  end
endmodule

// File: rtl/qp_mont_mac.sv
module qp_mont_mac
  import qp_mont_pkg::*;
#(
  parameter int unsigned DIG_W = 16,
  parameter int unsigned N_DIG = 5,
  parameter int unsigned OP_W  = DIG_W * N_DIG - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic [OP_W-1:0] c_i,
  input  logic [OP_W-1:0] d_i,
  input  logic [OP_W-1:0] mod_hat_i,
  output logic            done_o,
  output logic [OP_W-1:0] result_o
);
  localparam int unsigned N_IT     = N_DIG + 2;
  localparam int unsigned CNT_W    = $clog2(N_IT + 2);
  localparam int unsigned ACC_W    = DIG_W * (N_DIG + 3);
  localparam int unsigned BREG_W   = DIG_W * N_DIG;
  localparam int unsigned N_PROD   = 3;
  localparam int unsigned NROW     = 2 + N_PROD * DIG_W;
  localparam int unsigned MH_LIM_W = OP_W - 2 * DIG_W - 1;

  qp_state_e          state_q;
  logic [CNT_W-1:0]   it_cnt_q;
  logic [OP_W-1:0]    a_q, c_q, mh_q;
  logic [BREG_W-1:0]  b_q, d_q;
  logic [ACC_W-1:0]   s_q, cs_q;
  logic               cy_q;
  logic [DIG_W-1:0]   qd_q;

  logic [DIG_W-1:0]   q_cur;
  logic               cy_nxt;
  logic [ACC_W-1:0]   hi_s, hi_c;
  logic [ACC_W-1:0]   csa_s, csa_c;
  logic               csa_ovf;
  logic [ACC_W-1:0]   fin_sum;

  logic [DIG_W-1:0]            pp_dig [N_PROD];
  logic [OP_W-1:0]             pp_op  [N_PROD];
  logic [DIG_W-1:0][ACC_W-1:0] pp_rows [N_PROD];
  logic [NROW-1:0][ACC_W-1:0]  rows;

  // Quotient of this iteration; consumed by the next one.
  qp_digit_cpa #(.DIG_W(DIG_W)) u_lo_cpa (
    .sum_i   (s_q[DIG_W-1:0]),
    .carry_i (cs_q[DIG_W-1:0]),
    .cin_i   (cy_q),
    .q_o     (q_cur),
    .cout_o  (cy_nxt)
  );

  assign hi_s = s_q >> DIG_W;
  assign hi_c = cs_q >> DIG_W;

  // Delayed quotient times reduced modulus, then the two operand products.
  assign pp_dig[0] = qd_q;
  assign pp_op[0]  = mh_q;
  assign pp_dig[1] = b_q[DIG_W-1:0];
  assign pp_op[1]  = a_q;
  assign pp_dig[2] = d_q[DIG_W-1:0];
  assign pp_op[2]  = c_q;

  for (genvar g = 0; g < N_PROD; g++) begin : g_prod
    qp_pp_rows #(.DIG_W(DIG_W), .OP_W(OP_W), .ACC_W(ACC_W)) u_pp (
      .dig_i  (pp_dig[g]),
      .op_i   (pp_op[g]),
      .rows_o (pp_rows[g])
    );
  end

  always_comb begin
    rows[0] = hi_s;
    rows[1] = hi_c;
    for (int g = 0; g < N_PROD; g++) begin
      for (int j = 0; j < DIG_W; j++) begin
        rows[2 + g * DIG_W + j] = pp_rows[g][j];
      end
    end
  end

  qp_csa_reduce #(.NROW(NROW), .ACC_W(ACC_W)) u_csa (
    .rows_i  (rows),
    .sum_o   (csa_s),
    .carry_o (csa_c),
    .ovf_o   (csa_ovf)
  );

  assign fin_sum = s_q + cs_q + ACC_W'(cy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      it_cnt_q <= '0;
      a_q      <= '0;
      c_q      <= '0;
      mh_q     <= '0;
      b_q      <= '0;
      d_q      <= '0;
      s_q      <= '0;
      cs_q     <= '0;
      cy_q     <= 1'b0;
      qd_q     <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            a_q      <= a_i;
            c_q      <= c_i;
            mh_q     <= mod_hat_i;
            b_q      <= BREG_W'(b_i);
            d_q      <= BREG_W'(d_i);
            s_q      <= '0;
            cs_q     <= '0;
            cy_q     <= 1'b0;
            qd_q     <= '0;
            it_cnt_q <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          s_q      <= csa_s;
          cs_q     <= csa_c;
          cy_q     <= cy_nxt;
          qd_q     <= q_cur;
          b_q      <= b_q >> DIG_W;
          d_q      <= d_q >> DIG_W;
          it_cnt_q <= it_cnt_q + 1'b1;
          if (it_cnt_q == CNT_W'(N_IT - 1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          result_o <= {fin_sum[OP_W-DIG_W-1:0], qd_q};
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Assertion-only: edges since the accepted start.
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lat_q <= '0;
    else if (state_q == ST_IDLE && start_i) lat_q <= '0;
    else if (state_q != ST_IDLE)           lat_q <= lat_q + 1'b1;
  end

  logic mh_small;
  assign mh_small = (mh_q >> MH_LIM_W) == '0;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == (CNT_W + 1)'(N_IT + 1));

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i) |=> (it_cnt_q != '0 || state_q == ST_FIN));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> !csa_ovf);

  assert_result_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN && mh_small) |-> (fin_sum >> (OP_W - DIG_W)) == '0);
endmodule

// File: tb/qp_mont_mac_test.sv
module qp_mont_mac_test;
  localparam int unsigned DIG_W = 16;
  localparam int unsigned N_DIG = 5;
  localparam int unsigned OP_W  = DIG_W * N_DIG - 2;
  localparam int unsigned LAT   = N_DIG + 3;
  localparam int unsigned NVEC  = 6;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            start_i;
  logic [OP_W-1:0] a_i, b_i, c_i, d_i, mod_hat_i;
  logic            done_o;
  logic [OP_W-1:0] result_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  qp_mont_mac #(.DIG_W(DIG_W), .N_DIG(N_DIG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i), .mod_hat_i(mod_hat_i),
    .done_o(done_o), .result_o(result_o)
  );

  localparam logic [OP_W-1:0] TA [NVEC] = '{
    78'h1234_5678_9ABC_DEF0_1357, 78'h0000_0000_0000_0000_0003,
    78'h3FFF_FFFF_FFFF_FFFF_FFFF, 78'h2718_2818_2845_9045_2353,
    78'h0000_0001_0000_0000_0001, 78'h1111_2222_3333_4444_5555};
  localparam logic [OP_W-1:0] TB [NVEC] = '{
    78'h0FED_CBA9_8765_4321_0F0F, 78'h0000_0000_0000_0000_0005,
    78'h3FFF_FFFF_FFFF_FFFF_FFFF, 78'h1618_0339_8874_9894_8482,
    78'h3000_0000_0000_0000_0000, 78'h0000_0000_0000_0000_0000};
  localparam logic [OP_W-1:0] TC [NVEC] = '{
    78'h2468_ACE0_1357_9BDF_0246, 78'h0000_0000_0000_0000_0007,
    78'h3FFF_FFFF_FFFF_FFFF_FFFF, 78'h0000_0000_0000_0000_0000,
    78'h0000_FFFF_0000_FFFF_0000, 78'h3333_2222_1111_0000_FFFF};
  localparam logic [OP_W-1:0] TD [NVEC] = '{
    78'h3141_5926_5358_9793_2384, 78'h0000_0000_0000_0000_000B,
    78'h3FFF_FFFF_FFFF_FFFF_FFFF, 78'h0000_0000_0000_0000_0000,
    78'h0001_0001_0001_0001_0001, 78'h0ABC_0000_0000_0000_0001};
  localparam logic [63:0] TM [NVEC] = '{
    64'h1F0F_1234_5677, 64'h65, 64'h1FFF_FFFF_FFFF,
    64'h0ABC_DEF0_1235, 64'h1_0001, 64'h1234_5678_9ABB};

  // mod_hat from M: Newton inverse mod 2^(2*DIG_W), negate, scale, shift.
  function automatic logic [OP_W-1:0] mhat_of(input logic [63:0] m);
    logic [31:0]  inv, m32;
    logic [127:0] mt;
    m32 = m[31:0];
    inv = m32;
    for (int k = 0; k < 5; k++) inv = inv * (32'd2 - m32 * inv);
    mt = {96'b0, (~inv) + 32'd1} * {64'b0, m};
    mt = (mt + 128'd1) >> 32;
    return mt[OP_W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_mod(input string tag, input logic [OP_W-1:0] res,
                           input logic [OP_W-1:0] a, b, c, d, input logic [63:0] m);
    logic [255:0] lhs, rhs, mw;
    mw  = {192'b0, m};
    lhs = ({178'b0, res} << (DIG_W * N_DIG)) % mw;
    rhs = ({178'b0, a} * {178'b0, b} + {178'b0, c} * {178'b0, d}) % mw;
    check(lhs == rhs, tag, lhs, rhs);
  endtask

  task automatic run_op(input logic [OP_W-1:0] a, b, c, d, mh,
                        output logic [OP_W-1:0] res, output int lat, output bit pulse_ok);
    @(negedge clk);
    a_i = a; b_i = b; c_i = c; d_i = d; mod_hat_i = mh; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o || lat > 60) break;
    end
    res = result_o;
    @(negedge clk);
    pulse_ok = !done_o;
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [OP_W-1:0] res, r0, r1, prev;
    logic [OP_W-1:0] mh0;
    int lat;
    bit pulse_ok, held;

    rst_ni = 1'b0; start_i = 1'b0;
    a_i = '0; b_i = '0; c_i = '0; d_i = '0; mod_hat_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done_o == 1'b0 && result_o == '0, "R1 in reset", {result_o, done_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0 && result_o == '0, "R1 after release", {result_o, done_o}, '0);

    mh0 = mhat_of(TM[0]);
    r0  = '0;
    // Table walk: R3 throughout, R5 on C=D=0 row, R9 on all-ones row, R2 timing.
    for (int i = 0; i < NVEC; i++) begin
      run_op(TA[i], TB[i], TC[i], TD[i], mhat_of(TM[i]), res, lat, pulse_ok);
      if (i == 0) r0 = res;
      check_mod(i == 3 ? "R5 plain product" : (i == 2 ? "R9 all ones" : "R3 table"),
                res, TA[i], TB[i], TC[i], TD[i], TM[i]);
      check(lat == LAT, "R2 latency", lat, LAT);
      check(pulse_ok, "R2 single-cycle done", {255'b0, !pulse_ok}, '0);
    end

    // R8: zero operands, exact zero.
    run_op('0, '0, '0, '0, mh0, res, lat, pulse_ok);
    check(res == '0, "R8 zero operands", res, '0);

    // R6: results fed back as operands.
    run_op(r0, r0, r0, TB[0], mh0, r1, lat, pulse_ok);
    check_mod("R6 feedback", r1, r0, r0, r0, TB[0], TM[0]);
    run_op(r1, r1, '0, '0, mh0, res, lat, pulse_ok);
    check_mod("R6 feedback squared", res, r1, r1, '0, '0, TM[0]);

    // R7: second start mid-run with other operands is ignored.
    prev = result_o;
    held = 1'b1;
    @(negedge clk);
    a_i = TA[0]; b_i = TB[0]; c_i = TC[0]; d_i = TD[0]; mod_hat_i = mh0; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 2) begin
        a_i = TA[4]; b_i = TB[4]; c_i = TC[4]; d_i = TD[4];
        mod_hat_i = mhat_of(TM[4]); start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o || lat > 60) break;
      if (result_o != prev) held = 1'b0;
    end
    check(result_o == r0, "R7 result unchanged by mid-run start", result_o, r0);
    check(lat == LAT, "R7 latency unchanged", lat, LAT);
    check(held, "R7 result held until done", {255'b0, !held}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule